// File: doc/BRIEF.md
# Comparator Negative-Input Routing and Edge Interrupt Controller

This block sits beside an analog comparator that is outside its scope. It works out which source feeds the comparator's negative terminal and gives that choice as a select code. The source is either a dedicated pin or one of eight converter channels that share a multiplexer. The comparator's digital output is brought into the clock domain through a synchronizer. A programmable edge condition on that output sets a sticky interrupt flag. The interrupt output is the flag gated by an enable bit.

A byte-wide register port holds four locations: control, status, input-disable and masked pin readback. The input-disable bits turn off the digital path of the two comparator pins, so the readback bits for those pins return zero. The control fields, the converter-enable input and the converter multiplexer field together decide the negative-input select code.

Top module: `acmp_ctl`

## Requirements
- R1: After a synchronous reset every register bit is zero. The interrupt is low, the select code is 0, and every register reads 0.
- R2: The control register sits at address 0. Bit 0 is the interrupt enable, bits 2:1 are the edge mode and bit 3 is the shared-multiplexer enable. Bits 7:4 read as zero.
- R3: Edge mode 00 sets the flag on either edge of the comparator output. A new comparator level that is present at three consecutive rising clock edges shows on the interrupt after the third of those edges, and not after the second.
- R4: Edge mode 10 sets the flag on a falling edge of the synchronized comparator output and ignores a rising edge.
- R5: Edge mode 11 sets the flag on a rising edge and ignores a falling edge.
- R6: Edge mode 01 is reserved, and no comparator activity sets the flag in that mode.
- R7: The flag sits at bit 0 of the status register (address 1). It stays set until 1 is written to that bit. Writing 0 there leaves it set.
- R8: The interrupt output is high exactly when both the flag and the enable bit are high. The flag still sets while the enable bit is low.
- R9: Changing the mode field can set the flag with no comparator edge at all. With the synchronized level at 1, a switch from mode 10 to mode 11 sets the flag.
- R10: The select code is registered one cycle after its inputs. When the multiplexer enable is 1 and converter-enable is 0, the code is 8 plus the 3-bit converter mux value. In every other case it is 0 (the dedicated pin), whatever the mux field holds.
- R11: The input-disable register sits at address 2. Bit 1 covers the negative pin and bit 0 the positive pin. Bits 7:2 read as zero.
- R12: The pin readback register sits at address 3. Its bits 1:0 hold the raw pin bits, and each bit is forced to zero while its disable bit is 1. Bits 7:2 read as zero.
- R13: Read data is registered and holds the contents of the location addressed one cycle earlier. Status bit 1 shows the synchronized comparator level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cmp_out | input | 1 | Asynchronous comparator output |
| conv_en | input | 1 | Converter enabled |
| conv_mux | input | 3 | Converter channel field |
| pin_raw | input | 2 | Raw pin levels (bit 1 negative, bit 0 positive) |
| neg_sel | output | 4 | Negative-input select code |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the register port never writes and reads the same location in a way that depends on a same-cycle update. They also assume the comparator output holds each level for more than one clock, so every synchronized edge appears as a separate event. The stimulus changes the comparator level only at falling clock edges and then holds it for at least four cycles. It always clears the enable bit before it rewrites the mode field, and it clears any flag that the mode change produced before it enables the interrupt again.

// File: rtl/acmp_pkg.sv
package acmp_pkg;

  typedef enum logic [1:0] {
    EDGE_ANY  = 2'b00,
    EDGE_NONE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_RISE = 2'b11
  } edge_mode_t;

  typedef struct packed {
    logic       mux_en;
    edge_mode_t mode;
    logic       irq_en;
  } ctrl_t;

  localparam int unsigned ADR_CTRL = 0;
  localparam int unsigned ADR_STAT = 1;
  localparam int unsigned ADR_IDIS = 2;
  localparam int unsigned ADR_PINS = 3;

  localparam int unsigned CTRL_W        = 4;
  localparam int unsigned STAT_FLAG_BIT = 0;
  localparam int unsigned STAT_LVL_BIT  = 1;

endpackage

// File: rtl/acmp_edge.sv
module acmp_edge
  import acmp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmp_raw,
  input  edge_mode_t mode,
  output logic       lvl,
  output logic       set_evt
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   lvl_prev_q;
  logic                   qual;
  logic                   qual_prev_q;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[SYNC_STAGES-2:0], cmp_raw};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= cmp_raw;
      end
    end
  endgenerate

  assign lvl = chain_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_prev_q  <= 1'b0;
      qual_prev_q <= 1'b0;
    end else begin
      lvl_prev_q  <= lvl;
      qual_prev_q <= qual;
    end
  end

  // Mode-qualified condition; a rise of it is an interrupt event.
  always_comb begin
    unique case (mode)
      EDGE_ANY:  qual = lvl ^ lvl_prev_q;
      EDGE_FALL: qual = ~lvl;
      EDGE_RISE: qual = lvl;
      default:   qual = 1'b0;
    endcase
  end

  assign set_evt = qual & ~qual_prev_q;

endmodule

// File: rtl/acmp_regs.sv
module acmp_regs
  import acmp_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned NUM_PINS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                set_evt,
  input  logic                lvl,
  input  logic [NUM_PINS-1:0] pin_vis,
  output ctrl_t               ctrl_q,
  output logic [NUM_PINS-1:0] dis_q,
  output logic                flag_q,
  output logic [DATA_W-1:0]   rdata
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);
  localparam logic [ADDR_W-1:0] A_IDIS = ADDR_W'(ADR_IDIS);
  localparam logic [ADDR_W-1:0] A_PINS = ADDR_W'(ADR_PINS);

  logic              wr_ctrl, wr_stat, wr_idis, clr;
  logic [DATA_W-1:0] rd_n;

  assign wr_ctrl = wr && (addr == A_CTRL);
  assign wr_stat = wr && (addr == A_STAT);
  assign wr_idis = wr && (addr == A_IDIS);
  assign clr     = wr_stat && wdata[STAT_FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      dis_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_idis) dis_q  <= wdata[NUM_PINS-1:0];
    end
  end

  // Set has precedence over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr)     flag_q <= 1'b0;
  end

  always_comb begin
    rd_n = '0;
    unique case (addr)
      A_CTRL: rd_n[CTRL_W-1:0] = ctrl_q;
      A_STAT: begin
        rd_n[STAT_FLAG_BIT] = flag_q;
        rd_n[STAT_LVL_BIT]  = lvl;
      end
      A_IDIS: rd_n[NUM_PINS-1:0] = dis_q;
      A_PINS: rd_n[NUM_PINS-1:0] = pin_vis;
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_n;
  end

endmodule

// File: rtl/acmp_route.sv
module acmp_route #(
  parameter int unsigned MUX_W    = 3,
  parameter int unsigned NUM_PINS = 2,
  localparam int unsigned SEL_W   = MUX_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mux_en,
  input  logic                conv_en,
  input  logic [MUX_W-1:0]    conv_mux,
  input  logic [NUM_PINS-1:0] pin_raw,
  input  logic [NUM_PINS-1:0] dis,
  output logic [SEL_W-1:0]    neg_sel,
  output logic [NUM_PINS-1:0] pin_vis
);

  logic use_shared;

  assign use_shared = mux_en & ~conv_en;

  always_ff @(posedge clk) begin
    if (rst)             neg_sel <= '0;
    else if (use_shared) neg_sel <= {1'b1, conv_mux};
    else                 neg_sel <= '0;
  end

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign pin_vis[p] = pin_raw[p] & ~dis[p];
    end
  endgenerate

endmodule

// File: rtl/acmp_ctl.sv
module acmp_ctl
  import acmp_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned NUM_PINS    = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned MUX_W      = $clog2(NUM_CH),
  localparam int unsigned SEL_W      = MUX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cmp_out,
  input  logic              conv_en,
  input  logic [MUX_W-1:0]  conv_mux,
  input  logic [NUM_PINS-1:0] pin_raw,
  output logic [SEL_W-1:0]  neg_sel,
  output logic              irq
);

  ctrl_t               ctrl_q;
  logic [NUM_PINS-1:0] dis_q;
  logic [NUM_PINS-1:0] pin_vis;
  logic                flag_q;
  logic                lvl;
  logic                set_evt;
  logic [1:0]          mode_bits;
  logic                mux_en_bit;

  assign mode_bits  = ctrl_q.mode;
  assign mux_en_bit = ctrl_q.mux_en;

  acmp_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk     (clk),
    .rst     (rst),
    .cmp_raw (cmp_out),
    .mode    (ctrl_q.mode),
    .lvl     (lvl),
    .set_evt (set_evt)
  );

  acmp_regs #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .NUM_PINS (NUM_PINS)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .wr      (bus_wr),
    .wdata   (bus_wdata),
    .set_evt (set_evt),
    .lvl     (lvl),
    .pin_vis (pin_vis),
    .ctrl_q  (ctrl_q),
    .dis_q   (dis_q),
    .flag_q  (flag_q),
    .rdata   (bus_rdata)
  );

  acmp_route #(
    .MUX_W    (MUX_W),
    .NUM_PINS (NUM_PINS)
  ) u_route (
    .clk      (clk),
    .rst      (rst),
    .mux_en   (ctrl_q.mux_en),
    .conv_en  (conv_en),
    .conv_mux (conv_mux),
    .pin_raw  (pin_raw),
    .dis      (dis_q),
    .neg_sel  (neg_sel),
    .pin_vis  (pin_vis)
  );

  assign irq = flag_q & ctrl_q.irq_en;

endmodule

// File: rtl/acmp_ctl_chk.sv
module acmp_ctl_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned NUM_PINS = 2,
  parameter int unsigned SEL_W    = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                conv_en,
  input logic [SEL_W-1:0]    neg_sel,
  input logic [1:0]          mode,
  input logic                mux_en,
  input logic                flag,
  input logic                set_evt,
  input logic [NUM_PINS-1:0] dis
);

  logic clr_req;
  assign clr_req = bus_wr && (bus_addr == ADDR_W'(1)) && bus_wdata[0];

  AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && !flag) |=> !flag); // R6

  AST_SEL_DEDICATED: assert property (@(posedge clk) disable iff (rst)
    (!mux_en || conv_en) |=> (neg_sel == '0)); // R10

  AST_SEL_SHARED: assert property (@(posedge clk) disable iff (rst)
    (mux_en && !conv_en) |=> neg_sel[SEL_W-1]); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_req) |=> flag); // R7

  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !set_evt) |=> !flag); // R7

  AST_PINS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(3)) |=> (bus_rdata[DATA_W-1:NUM_PINS] == '0)); // R12

  AST_PIN_MASKED: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(3) && dis[NUM_PINS-1]) |=> !bus_rdata[NUM_PINS-1]); // R12

endmodule

bind acmp_ctl acmp_ctl_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .NUM_PINS (NUM_PINS),
  .SEL_W    (SEL_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .conv_en   (conv_en),
  .neg_sel   (neg_sel),
  .mode      (mode_bits),
  .mux_en    (mux_en_bit),
  .flag      (flag_q),
  .set_evt   (set_evt),
  .dis       (dis_q)
);

// File: tb/acmp_ctl_test.sv
module acmp_ctl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cmp_out = 1'b0;
  logic       conv_en = 1'b0;
  logic [2:0] conv_mux = '0;
  logic [1:0] pin_raw = '0;
  logic [3:0] neg_sel;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit started = 0;

  always #5 clk = ~clk;

  acmp_ctl uut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cmp_out   (cmp_out),
    .conv_en   (conv_en),
    .conv_mux  (conv_mux),
    .pin_raw   (pin_raw),
    .neg_sel   (neg_sel),
    .irq       (irq)
  );

  // Behavioural reference: state as plain variables, updated each edge.
  int   m_s1, m_s2, m_s3, m_qp, m_flag, m_en, m_mode, m_mux, m_dis;
  int   m_sel, m_rd;

  always @(posedge clk) begin
    int q, nf, rd, sel;
    started = 1;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_qp = 0; m_flag = 0;
      m_en = 0; m_mode = 0; m_mux = 0; m_dis = 0; m_sel = 0; m_rd = 0;
    end else begin
      if      (m_mode == 0) q = (m_s2 != m_s3) ? 1 : 0;
      else if (m_mode == 2) q = m_s2 ? 0 : 1;
      else if (m_mode == 3) q = m_s2;
      else                  q = 0;
      nf = m_flag;
      if (bus_wr && bus_addr == 1 && bus_wdata[0]) nf = 0;
      if (q == 1 && m_qp == 0) nf = 1;
      case (bus_addr)
        0: rd = m_mux * 8 + m_mode * 2 + m_en;
        1: rd = m_s2 * 2 + m_flag;
        2: rd = m_dis;
        default: rd = int'(pin_raw) & (3 - m_dis);
      endcase
      sel = (m_mux == 1 && !conv_en) ? 8 + int'(conv_mux) : 0;
      if (bus_wr && bus_addr == 0) begin
        m_en = bus_wdata[0]; m_mode = int'(bus_wdata[2:1]); m_mux = bus_wdata[3];
      end
      if (bus_wr && bus_addr == 2) m_dis = int'(bus_wdata[1:0]);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cmp_out;
      m_qp = q; m_flag = nf; m_rd = rd; m_sel = sel;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      check("R8 irq vs model", int'(irq), m_flag & m_en);
      check("R10 neg_sel vs model", int'(neg_sel), m_sel);
      check("R13 rdata vs model", int'(bus_rdata), m_rd);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 2'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    bus_addr = 2'(a); bus_wr = 1'b0;
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int v;
    wcyc(3);
    rst = 1'b0;
    // R1: reset state
    check("R1 irq", int'(irq), 0);
    check("R1 neg_sel", int'(neg_sel), 0);
    rd(0, v); check("R1 ctrl", v, 0);
    rd(1, v); check("R1 stat", v, 0);
    rd(2, v); check("R1 idis", v, 0);

    // R10: routing
    conv_mux = 3'd5; conv_en = 1'b0;
    wr(0, 8'h08); wcyc(1);
    check("R10 shared ch5", int'(neg_sel), 13);
    conv_en = 1'b1; wcyc(1);
    check("R10 conv on", int'(neg_sel), 0);
    conv_en = 1'b0; conv_mux = 3'd0; wcyc(1);
    check("R10 shared ch0", int'(neg_sel), 8);
    conv_mux = 3'd7; wcyc(1);
    check("R10 shared ch7", int'(neg_sel), 15);
    wr(0, 8'h00); wcyc(1);
    check("R10 mux off", int'(neg_sel), 0);

    // R3: toggle mode, timing and both edges
    wr(0, 8'h01); wr(1, 8'h01);
    cmp_out = 1'b1; wcyc(2);
    check("R3 not yet", int'(irq), 0);
    wcyc(1);
    check("R3 rise seen", int'(irq), 1);
    wr(1, 8'h01);
    check("R3 cleared", int'(irq), 0);
    cmp_out = 1'b0; wcyc(4);
    check("R3 fall seen", int'(irq), 1);
    wr(1, 8'h01);

    // R4: falling mode
    wr(0, 8'h00); wr(0, 8'h04); wr(1, 8'h01); wr(0, 8'h05);
    cmp_out = 1'b1; wcyc(4);
    check("R4 rise ignored", int'(irq), 0);
    cmp_out = 1'b0; wcyc(4);
    check("R4 fall seen", int'(irq), 1);
    wr(1, 8'h01);

    // R5: rising mode
    wr(0, 8'h04); wr(0, 8'h06); wr(1, 8'h01); wr(0, 8'h07);
    cmp_out = 1'b1; wcyc(4);
    check("R5 rise seen", int'(irq), 1);
    wr(1, 8'h01);
    cmp_out = 1'b0; wcyc(4);
    check("R5 fall ignored", int'(irq), 0);

    // R9: spurious flag from mode change
    wr(0, 8'h06); wr(0, 8'h00);
    cmp_out = 1'b1; wcyc(4);
    wr(0, 8'h04); wr(1, 8'h01);
    rd(1, v); check("R13 level shown, flag clear", v, 2);
    wr(0, 8'h06);
    rd(1, v); check("R9 mode switch sets flag", v, 3);
    wr(1, 8'h01);

    // R6: reserved mode
    wr(0, 8'h02); wr(1, 8'h01); wr(0, 8'h03);
    cmp_out = 1'b0; wcyc(4);
    cmp_out = 1'b1; wcyc(4);
    check("R6 no irq", int'(irq), 0);
    rd(1, v); check("R6 flag stays clear", v, 2);
    wr(0, 8'h02);
    cmp_out = 1'b0; wcyc(4);

    // R8 and R7: gating and stickiness
    wr(0, 8'h00); wr(1, 8'h01);
    cmp_out = 1'b1; wcyc(4);
    check("R8 gated off", int'(irq), 0);
    rd(1, v); check("R8 flag set while disabled", v, 3);
    wr(0, 8'h01);
    check("R8 enable exposes flag", int'(irq), 1);
    wr(1, 8'h00);
    check("R7 write 0 keeps flag", int'(irq), 1);
    wr(1, 8'h01);
    check("R7 write 1 clears", int'(irq), 0);

    // R11 and R12: disable and pin readback
    pin_raw = 2'b11;
    wr(2, 8'hFF);
    rd(2, v); check("R11 idis readback", v, 3);
    rd(3, v); check("R12 both masked", v, 0);
    wr(2, 8'h01);
    rd(3, v); check("R12 positive masked", v, 2);
    wr(2, 8'h02);
    rd(3, v); check("R12 negative masked", v, 1);
    wr(2, 8'h00);
    rd(3, v); check("R12 none masked", v, 3);

    // R2: control readback
    wr(0, 8'h00); wr(1, 8'h01);
    wr(0, 8'hFF);
    rd(0, v); check("R2 ctrl upper zero", v, 8'h0F);
    wr(0, 8'h00);

    // R1: mid-run reset
    wr(2, 8'h03);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 irq after reset", int'(irq), 0);
    check("R1 sel after reset", int'(neg_sel), 0);
    rd(2, v); check("R1 idis after reset", v, 0);

    wcyc(2);
    finish_run();
  end

endmodule